// File: doc/BRIEF.md
# Polled Keyboard and Display Register Port

This block is a bus-slave peripheral that links a processor to one character input device and one character output device. Software reaches the devices through four byte-wide registers placed at consecutive offsets from a base address. It polls the status bytes and moves characters through the data bytes, so it needs no interrupt or DMA path.

On the device side, a keyboard strobe delivers one byte at a time. A display handshake presents each written byte with a one-cycle valid pulse and takes back a done pulse once the character has been shown. The status flags change as side effects of data-register accesses. Reading the keyboard data clears input-ready. Writing the display data clears output-ready. A keyboard character that arrives before the previous one was read raises an overrun bit.

The processor bus is synchronous. A read strobe in one cycle returns its byte on `bus_rdata` in the next cycle. A write strobe takes effect at the clock edge on which it is sampled.

Top module: `kbd_disp_port`

## Requirements
- R1: After reset, keyboard data reads 0x00, keyboard status reads 0x00, display status reads 0x04, and `disp_vld` is low.
- R2: The registers sit at BASE+0 (keyboard data), BASE+1 (keyboard status), BASE+2 (display data) and BASE+3 (display status). BASE is aligned to 4 and defaults to 0x40. A read returns its byte in the cycle after the read strobe. A read outside the window returns 0x00. In a cycle that follows no read, `bus_rdata` is 0x00.
- R3: A `key_stb` cycle latches `key_byte` into keyboard data and sets input-ready, which is bit 1 (mask 0x02) of keyboard status.
- R4: A read of keyboard data returns the latched byte and clears input-ready. The byte itself stays in the register.
- R5: A strobe while input-ready is set overwrites keyboard data and sets overrun, which is bit 0 (mask 0x01) of keyboard status. The next keyboard status read returns overrun set and clears it.
- R6: If a keyboard data read and a strobe fall in the same cycle, the read returns the old byte, the new byte is latched, input-ready stays set and overrun is not raised.
- R7: A write to display data drives the byte on `disp_byte`, pulses `disp_vld` high for exactly the next cycle, and clears output-ready, which is bit 2 (mask 0x04) of display status.
- R8: A `disp_done` pulse sets output-ready. If `disp_done` and a display data write share a cycle, the write wins and output-ready ends clear.
- R9: Writes to keyboard data, keyboard status and display status change no register. Unused status bits always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address from the processor |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | BYTE_W | Write data |
| bus_rdata | output | BYTE_W | Read data, valid the cycle after a read |
| key_stb | input | 1 | Keyboard character strobe |
| key_byte | input | BYTE_W | Keyboard character |
| disp_byte | output | BYTE_W | Character presented to the display |
| disp_vld | output | 1 | One-cycle pulse that presents a new character |
| disp_done | input | 1 | Display has finished the character |

## Verification
The assertions take for granted that the processor never raises `bus_rd` and `bus_wr` in the same cycle. They also take for granted that every strobe and done input is a clean one-cycle level sampled at the clock edge. The bench drives each bus operation as a single strobe cycle set up on the falling edge, and it never combines a read with a write. Keyboard strobes and display done pulses go in only where a scenario calls for them. Where a collision with a bus access is wanted (R6, R8), the bench creates it on purpose.

// File: rtl/kdp_pkg.sv
package kdp_pkg;
  parameter int BYTE_W = 8;

  localparam logic [1:0] OFS_KDATA = 2'd0;
  localparam logic [1:0] OFS_KSTAT = 2'd1;
  localparam logic [1:0] OFS_DDATA = 2'd2;
  localparam logic [1:0] OFS_DSTAT = 2'd3;

  localparam int BIT_OVR  = 0;
  localparam int BIT_KRDY = 1;
  localparam int BIT_DRDY = 2;

  function automatic logic [BYTE_W-1:0] kstat_byte(input logic rdy, input logic ovr);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[BIT_KRDY] = rdy;
    b[BIT_OVR]  = ovr;
    return b;
  endfunction

  function automatic logic [BYTE_W-1:0] dstat_byte(input logic rdy);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[BIT_DRDY] = rdy;
    return b;
  endfunction
endpackage

// File: rtl/kdp_decode.sv
module kdp_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h40
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              hit,
  output logic [1:0]        ofs,
  output logic              kdata_rd,
  output logic              kstat_rd,
  output logic              ddata_wr,
  output logic              any_rd
);
  import kdp_pkg::*;
  localparam int TAG_W = ADDR_W - 2;

  assign hit      = (addr[ADDR_W-1:2] == BASE[ADDR_W-1:2]);
  assign ofs      = addr[1:0];
  assign any_rd   = rd && hit;
  assign kdata_rd = rd && hit && (ofs == OFS_KDATA);
  assign kstat_rd = rd && hit && (ofs == OFS_KSTAT);
  assign ddata_wr = wr && hit && (ofs == OFS_DDATA);

  // R2: the decoded events are mutually exclusive
  always_comb begin
    assert_onehot_evt_R2: assert ($onehot0({kdata_rd, kstat_rd, ddata_wr}) || (rd && wr));
  end

  if (TAG_W < 1) begin : g_bad
    initial $error("ADDR_W too small");
  end
endmodule

// File: rtl/kdp_kbd_side.sv
module kdp_kbd_side #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_stb,
  input  logic [BYTE_W-1:0] key_byte,
  input  logic              data_rd,
  input  logic              stat_rd,
  output logic [BYTE_W-1:0] kdata,
  output logic              krdy,
  output logic              kovr
);
  logic overrun_evt;
  assign overrun_evt = key_stb && krdy && !data_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kdata <= '0;
      krdy  <= 1'b0;
      kovr  <= 1'b0;
    end else begin
      if (key_stb) begin
        kdata <= key_byte;
        krdy  <= 1'b1;
      end else if (data_rd) begin
        krdy  <= 1'b0;
      end
      if (overrun_evt)  kovr <= 1'b1;
      else if (stat_rd) kovr <= 1'b0;
    end
  end

  assert_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    key_stb |=> (krdy && kdata == $past(key_byte)));
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !key_stb) |=> (!krdy && $stable(kdata)));
  assert_ovr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> kovr);
  assert_ovr_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !overrun_evt) |=> !kovr);
  assert_collide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && key_stb && !kovr) |=> (krdy && !kovr));
endmodule

// File: rtl/kdp_disp_side.sv
module kdp_disp_side #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              done,
  output logic [BYTE_W-1:0] dbyte,
  output logic              dvld,
  output logic              drdy
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbyte <= '0;
      dvld  <= 1'b0;
      drdy  <= 1'b1;
    end else begin
      dvld <= wr_evt;
      if (wr_evt) begin
        dbyte <= wdata;
        drdy  <= 1'b0;
      end else if (done) begin
        drdy  <= 1'b1;
      end
    end
  end

  assert_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> (dvld && !drdy && dbyte == $past(wdata)));
  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> !dvld);
  assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_evt) |=> drdy);
endmodule

// File: rtl/kbd_disp_port.sv
module kbd_disp_port #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h40,
  parameter int BYTE_W = kdp_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              key_stb,
  input  logic [BYTE_W-1:0] key_byte,
  output logic [BYTE_W-1:0] disp_byte,
  output logic              disp_vld,
  input  logic              disp_done
);
  import kdp_pkg::*;

  logic              hit, kdata_rd, kstat_rd, ddata_wr, any_rd;
  logic [1:0]        ofs;
  logic [BYTE_W-1:0] kdata;
  logic              krdy, kovr, drdy;
  logic [BYTE_W-1:0] rd_mux;

  kdp_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .hit(hit), .ofs(ofs),
    .kdata_rd(kdata_rd), .kstat_rd(kstat_rd), .ddata_wr(ddata_wr), .any_rd(any_rd)
  );

  kdp_kbd_side #(.BYTE_W(BYTE_W)) u_kbd (
    .clk(clk), .rst_n(rst_n), .key_stb(key_stb), .key_byte(key_byte),
    .data_rd(kdata_rd), .stat_rd(kstat_rd), .kdata(kdata), .krdy(krdy), .kovr(kovr)
  );

  kdp_disp_side #(.BYTE_W(BYTE_W)) u_disp (
    .clk(clk), .rst_n(rst_n), .wr_evt(ddata_wr), .wdata(bus_wdata), .done(disp_done),
    .dbyte(disp_byte), .dvld(disp_vld), .drdy(drdy)
  );

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      unique case (ofs)
        OFS_KDATA: rd_mux = kdata;
        OFS_KSTAT: rd_mux = kstat_byte(krdy, kovr);
        OFS_DDATA: rd_mux = disp_byte;
        OFS_DSTAT: rd_mux = dstat_byte(drdy);
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= any_rd ? rd_mux : '0;
  end

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));
  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit) |=> (bus_rdata == '0));
  assert_unused_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (kstat_rd) |=> ((bus_rdata & ~8'h03) == '0));
endmodule

// File: tb/kbd_disp_port_bench.sv
module kbd_disp_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       key_stb = 1'b0;
  logic [7:0] key_byte = '0, disp_byte;
  logic       disp_vld, disp_done = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  kbd_disp_port u_kbd_disp_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_stb(key_stb), .key_byte(key_byte),
    .disp_byte(disp_byte), .disp_vld(disp_vld), .disp_done(disp_done)
  );

  localparam logic [2:0] OP_STB = 3'd1, OP_RD = 3'd2, OP_WR = 3'd3, OP_DONE = 3'd4;
  // {req[3:0], op[2:0], addr[7:0], data[7:0], expected[7:0]}
  localparam int NV = 24;
  localparam logic [30:0] VEC [NV] = '{
    {4'd1, OP_RD,   8'h41, 8'h00, 8'h00},
    {4'd1, OP_RD,   8'h43, 8'h00, 8'h04},
    {4'd1, OP_RD,   8'h40, 8'h00, 8'h00},
    {4'd3, OP_STB,  8'h00, 8'h41, 8'h00},
    {4'd3, OP_RD,   8'h41, 8'h00, 8'h02},
    {4'd4, OP_RD,   8'h40, 8'h00, 8'h41},
    {4'd4, OP_RD,   8'h41, 8'h00, 8'h00},
    {4'd5, OP_STB,  8'h00, 8'h42, 8'h00},
    {4'd5, OP_STB,  8'h00, 8'h43, 8'h00},
    {4'd5, OP_RD,   8'h41, 8'h00, 8'h03},
    {4'd5, OP_RD,   8'h41, 8'h00, 8'h02},
    {4'd5, OP_RD,   8'h40, 8'h00, 8'h43},
    {4'd7, OP_WR,   8'h42, 8'h5A, 8'h00},
    {4'd7, OP_RD,   8'h43, 8'h00, 8'h00},
    {4'd7, OP_RD,   8'h42, 8'h00, 8'h5A},
    {4'd8, OP_DONE, 8'h00, 8'h00, 8'h00},
    {4'd8, OP_RD,   8'h43, 8'h00, 8'h04},
    {4'd9, OP_WR,   8'h40, 8'hFF, 8'h00},
    {4'd9, OP_WR,   8'h41, 8'hFF, 8'h00},
    {4'd9, OP_WR,   8'h43, 8'h00, 8'h00},
    {4'd9, OP_RD,   8'h41, 8'h00, 8'h00},
    {4'd9, OP_RD,   8'h40, 8'h00, 8'h43},
    {4'd2, OP_RD,   8'h44, 8'h00, 8'h00},
    {4'd2, OP_RD,   8'h3F, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one operation cycle: inputs set on a falling edge, cleared on the next
  task automatic do_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    case (op)
      OP_STB:  begin key_stb = 1'b1; key_byte = d; end
      OP_RD:   bus_rd = 1'b1;
      OP_WR:   begin bus_wr = 1'b1; bus_wdata = d; end
      OP_DONE: disp_done = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    key_stb = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; disp_done = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    do_op(OP_RD, a, 8'h00);
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 disp_vld", {7'd0, disp_vld}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][26:24], VEC[i][23:16], VEC[i][15:8]);
      if (VEC[i][26:24] == OP_RD)
        check($sformatf("R%0d vec%0d", VEC[i][30:27], i), bus_rdata, VEC[i][7:0]);
    end

    // R2: idle cycle after a read returns zero
    @(negedge clk);
    check("R2 idle", bus_rdata, 8'h00);

    // R6: read and strobe collide
    do_op(OP_STB, 8'h00, 8'h11);
    @(negedge clk);
    bus_addr = 8'h40; bus_rd = 1'b1; key_stb = 1'b1; key_byte = 8'h22;
    @(negedge clk);
    bus_rd = 1'b0; key_stb = 1'b0;
    check("R6 old byte", bus_rdata, 8'h11);
    rd_chk("R6 status", 8'h41, 8'h02);
    rd_chk("R6 new byte", 8'h40, 8'h22);

    // R7: valid pulse lasts one cycle and carries the byte
    @(negedge clk);
    bus_addr = 8'h42; bus_wr = 1'b1; bus_wdata = 8'hA5;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R7 vld high", {7'd0, disp_vld}, 8'h01);
    check("R7 byte", disp_byte, 8'hA5);
    @(negedge clk);
    check("R7 vld low", {7'd0, disp_vld}, 8'h00);

    // R8: done and write in the same cycle, write wins
    do_op(OP_DONE, 8'h00, 8'h00);
    @(negedge clk);
    bus_addr = 8'h42; bus_wr = 1'b1; bus_wdata = 8'h3C; disp_done = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; disp_done = 1'b0;
    rd_chk("R8 write wins", 8'h43, 8'h00);
    do_op(OP_DONE, 8'h00, 8'h00);
    rd_chk("R8 done sets", 8'h43, 8'h04);

    // R1: reset again restores the initial state
    do_op(OP_STB, 8'h00, 8'h99);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R1 kstat after reset", 8'h41, 8'h00);
    rd_chk("R1 kdata after reset", 8'h40, 8'h00);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule